// File: doc/BRIEF.md
# MII Nibble Receive Frame Controller

This block accepts an Ethernet frame arriving four bits per clock, each nibble qualified by a receive-valid strobe. It first hunts through a preamble of any length (including none) for the start-of-frame nibble. Once it has found that nibble, it passes every later nibble through a short fixed-latency delay line into a CRC-32 checker that works four bits per clock. Downstream logic sees the frame body as a strobed nibble stream.

When the valid strobe falls, the controller does three things in order. It lets the nibbles still in the delay line drain into the checker. It waits one clock for the registered CRC verdict. Then it reports the frame with a one-clock done pulse and two mutually exclusive status flags. A frame whose delimiter is wrong, or that ends before the delimiter, is reported as an error and delivers no data. The controller ignores the valid strobe until its end sequence has returned it to idle.

Top module: `mii_rx_frame_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `data_en`, `frame_done`, `crc_good` and `frame_err` are 0.
- R2: Any number (zero or more) of 0x5 nibbles followed by a 0xD nibble starts reception. Every nibble after the 0xD appears once on `data_nib`, in arrival order, with `data_en` high, two clocks after it was presented. The 0x5 and 0xD nibbles themselves never appear.
- R3: If a nibble other than 0x5 or 0xD arrives before the start nibble, no nibble of that frame is delivered. When valid falls, the frame is reported with `frame_err`=1 and `crc_good`=0.
- R4: If valid falls before the start nibble, `frame_done` is high in the first clock after the edge that sampled valid low, with `frame_err`=1 and `crc_good`=0.
- R5: After valid falls during reception, `data_en` stays high for exactly two more clocks, carrying the last two nibbles of the frame, and then goes low.
- R6: The check uses CRC-32 (polynomial 0x04C11DB7), preset to all ones. Nibbles are taken low nibble of each byte first, each fed LSB first. A frame is good when the register, read in normal bit order after the last nibble, equals 0xC704DD7B. A frame carrying its correct FCS (the complement of the CRC over the preceding nibbles, sent bit 0 first) is reported with `crc_good`=1 and `frame_err`=0.
- R7: A frame with any single bit flipped is reported with `frame_err`=1 and `crc_good`=0.
- R8: A frame with fewer than 8 nibbles after the start nibble is reported as an error. Exactly 8 nibbles forming a correct FCS over an empty body is good.
- R9: For a received frame, `frame_done` is high in the fourth clock after the edge that sampled valid low. It is exactly one clock wide, and exactly one of `crc_good`/`frame_err` is set while it is high. Both flags hold their values until the next `frame_done`.
- R10: Valid pulses and 0xD nibbles arriving during the drain, verdict or report clocks are ignored: nothing is delivered and the frame's report is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Nibble qualifier from the line interface |
| rx_nib | input | 4 | Received nibble |
| data_en | output | 1 | Strobe for `data_nib` (frame body nibbles) |
| data_nib | output | 4 | Delayed frame body nibble |
| frame_done | output | 1 | One-clock frame report pulse |
| crc_good | output | 1 | Last frame passed CRC and length |
| frame_err | output | 1 | Last frame failed |

## Verification
The bench targets the edges of the end sequence. A design that counted the drain wrongly would cut off or repeat the last nibble, or report before the delay line emptied; the checks catch this by sampling `data_en` on each clock after valid falls and the clock of `frame_done`. Preambles of zero length and of random length, wrong delimiters, and drops during hunting probe the hunt logic: a hunter that needed a preamble, or restarted on a later 0xD, would deliver data it should drop. Bodies of exactly eight nibbles and of fewer, plus single-bit flips, probe the length and CRC gates. Valid pulses injected during drain, verdict and report show whether the controller reopens too early.

// File: rtl/mii_rx_pkg.sv
// Package: shared state encoding and CRC constants for the nibble receiver.
// Assumes the CRC register is kept in reflected (LSB = x^31) orientation.
package mii_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_BAD,
        ST_RECV,
        ST_DRAIN,
        ST_VERDICT,
        ST_FINISH
    } rx_state_t;

    // Reflected form of 0x04C11DB7.
    localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
    // Reflected form of the good-frame residue 0xC704DD7B.
    localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;

endpackage

// File: rtl/mii_rx_delay.sv
// Delay line: fixed-latency shift register with a valid bit per stage.
// Assumes push is asserted for exactly the nibbles that belong to the frame
// body; output valid mirrors push DEPTH clocks later.
module mii_rx_delay #(
    parameter int NIB_W = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [NIB_W-1:0] din,
    output logic             dout_vld,
    output logic [NIB_W-1:0] dout
);

    logic [NIB_W-1:0] stg [DEPTH];
    logic [DEPTH-1:0] vld;

    // Shift data and valid one stage per clock; reset empties the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            vld[0] <= push;
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                vld[i] <= vld[i-1];
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout_vld = vld[DEPTH-1];
    assign dout     = stg[DEPTH-1];

endmodule

// File: rtl/mii_rx_fcs.sv
// FCS checker: CRC-32 over NIB_W bits per clock, LSB of each nibble first,
// with a registered residue compare. Assumes clear and en never coincide.
module mii_rx_fcs
    import mii_rx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [NIB_W-1:0] din,
    output logic             crc_ok
);

    logic [31:0] crc_q;
    logic [31:0] crc_d;
    logic        fb;

    // Bit-serial unroll of the reflected CRC over one nibble.
    always_comb begin
        crc_d = crc_q;
        fb    = 1'b0;
        for (int b = 0; b < NIB_W; b++) begin
            fb    = crc_d[0] ^ din[b];
            crc_d = {1'b0, crc_d[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
        end
    end

    // CRC register: preset on reset or clear, advance on each valid nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= '1;
        else if (en)         crc_q <= crc_d;
    end

    // Registered residue compare, one clock behind the register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_ok <= 1'b0;
        else        crc_ok <= (crc_q == CRC_RESIDUE_REFL);
    end

    // R6
    feed_vs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !clear)
        else $error("nibble fed while CRC preset");

endmodule

// File: rtl/mii_rx_fsm.sv
// Control FSM: preamble hunt, frame receive, drain, verdict and report.
// Assumes crc_ok is valid one clock after the last nibble enters the checker
// and that the delay line has DEPTH stages.
module mii_rx_fsm
    import mii_rx_pkg::*;
#(
    parameter int          NIB_W       = 4,
    parameter int          DEPTH       = 2,
    parameter int          MIN_NIBBLES = 8,
    parameter logic [3:0]  PRE_NIB     = 4'h5,
    parameter logic [3:0]  SFD_NIB     = 4'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [NIB_W-1:0] rx_nib,
    input  logic             crc_ok,
    output logic             capture,
    output logic             crc_clear,
    output logic             draining,
    output logic             frame_done,
    output logic             crc_good,
    output logic             frame_err
);

    localparam int LEN_W = $clog2(MIN_NIBBLES + 1);
    localparam int DRN_W = $clog2(DEPTH + 1);

    rx_state_t        state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [DRN_W-1:0] drn_q;
    logic             len_ok;
    logic             verdict_good;
    rx_state_t        hunt_next;

    assign len_ok       = (len_q == LEN_W'(MIN_NIBBLES));
    assign verdict_good = (state_q == ST_VERDICT) && crc_ok && len_ok;

    // Classify the current nibble while hunting for the start nibble.
    always_comb begin
        if (rx_nib == NIB_W'(SFD_NIB))      hunt_next = ST_RECV;
        else if (rx_nib == NIB_W'(PRE_NIB)) hunt_next = ST_HUNT;
        else                                hunt_next = ST_BAD;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (rx_valid) state_d = hunt_next;
            ST_HUNT:    state_d = rx_valid ? hunt_next : ST_FINISH;
            ST_BAD:     if (!rx_valid) state_d = ST_FINISH;
            ST_RECV:    if (!rx_valid) state_d = ST_DRAIN;
            ST_DRAIN:   if (drn_q == DRN_W'(DEPTH - 1)) state_d = ST_VERDICT;
            ST_VERDICT: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Body length counter, saturating at the minimum length.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE)   len_q <= '0;
        else if (capture && !len_ok)        len_q <= len_q + 1'b1;
    end

    // Drain counter: clocks spent emptying the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_DRAIN) drn_q <= '0;
        else                               drn_q <= drn_q + 1'b1;
    end

    // Status flags: loaded on entry to the report state, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_good  <= 1'b0;
            frame_err <= 1'b0;
        end else if (state_d == ST_FINISH && state_q != ST_FINISH) begin
            crc_good  <= verdict_good;
            frame_err <= !verdict_good;
        end
    end

    assign capture    = (state_q == ST_RECV) && rx_valid;
    assign crc_clear  = (state_q == ST_IDLE);
    assign draining   = (state_q == ST_DRAIN);
    assign frame_done = (state_q == ST_FINISH);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done)
        else $error("done wider than one clock");

    // R9
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (crc_good ^ frame_err))
        else $error("status flags not exclusive at done");

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable({crc_good, frame_err}))
        else $error("status flags moved outside report");

    // R8
    short_never_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && crc_good) |-> len_ok)
        else $error("short frame reported good");

endmodule

// File: rtl/mii_rx_frame_ctrl.sv
// Top: nibble receive frame controller. Wires the FSM, the delay line and
// the FCS checker. Assumes rx_nib is synchronous to clk and qualified by
// rx_valid; frames arriving before the controller returns to idle are dropped.
module mii_rx_frame_ctrl #(
    parameter int         NIB_W       = 4,
    parameter int         DEPTH       = 2,
    parameter int         MIN_NIBBLES = 8,
    parameter logic [3:0] PRE_NIB     = 4'h5,
    parameter logic [3:0] SFD_NIB     = 4'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [NIB_W-1:0] rx_nib,
    output logic             data_en,
    output logic [NIB_W-1:0] data_nib,
    output logic             frame_done,
    output logic             crc_good,
    output logic             frame_err
);

    logic capture;
    logic crc_clear;
    logic crc_ok;
    logic draining;

    mii_rx_fsm #(
        .NIB_W(NIB_W), .DEPTH(DEPTH), .MIN_NIBBLES(MIN_NIBBLES),
        .PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_nib(rx_nib),
        .crc_ok(crc_ok), .capture(capture), .crc_clear(crc_clear),
        .draining(draining), .frame_done(frame_done),
        .crc_good(crc_good), .frame_err(frame_err)
    );

    mii_rx_delay #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_delay (
        .clk(clk), .rst_n(rst_n), .push(capture), .din(rx_nib),
        .dout_vld(data_en), .dout(data_nib)
    );

    mii_rx_fcs #(.NIB_W(NIB_W)) u_fcs (
        .clk(clk), .rst_n(rst_n), .clear(crc_clear), .en(data_en),
        .din(data_nib), .crc_ok(crc_ok)
    );

    // R5
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_en) |-> draining)
        else $error("data strobe ended outside the drain");

    // R9
    report_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !data_en)
        else $error("report before delay line emptied");

endmodule

// File: tb/mii_rx_frame_ctrl_bench.sv
`timescale 1ns/1ps
module mii_rx_frame_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [3:0] rx_nib = 4'h0;
    logic       data_en;
    logic [3:0] data_nib;
    logic       frame_done;
    logic       crc_good;
    logic       frame_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [3:0] tx_nib [0:127];
    int         tx_len;
    logic [3:0] rx_got [0:127];
    int         rx_cnt = 0;

    always #2.5 clk = ~clk;

    mii_rx_frame_ctrl u_mii_rx_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_nib(rx_nib),
        .data_en(data_en), .data_nib(data_nib), .frame_done(frame_done),
        .crc_good(crc_good), .frame_err(frame_err)
    );

    // Collect the delivered body stream.
    always @(negedge clk) begin
        if (rst_n && data_en && rx_cnt < 128) begin
            rx_got[rx_cnt] = data_nib;
            rx_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [3:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 4; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Body of nbytes random bytes plus correct FCS, optionally one bit flipped.
    task automatic build_good(input int nbytes, input bit corrupt);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [7:0]  b;
        tx_len = 0;
        for (int i = 0; i < nbytes; i++) begin
            b = 8'($urandom);
            tx_nib[tx_len] = b[3:0]; tx_len++;
            tx_nib[tx_len] = b[7:4]; tx_len++;
        end
        for (int i = 0; i < tx_len; i++) c = crc_step(c, tx_nib[i]);
        c = ~c;
        for (int j = 0; j < 8; j++) begin
            tx_nib[tx_len] = c[4*j +: 4]; tx_len++;
        end
        if (corrupt) begin
            int idx = int'($urandom_range(0, tx_len - 1));
            tx_nib[idx] = tx_nib[idx] ^ (4'h1 << $urandom_range(0, 3));
        end
    endtask

    task automatic build_raw(input int n);
        tx_len = n;
        for (int i = 0; i < n; i++) tx_nib[i] = 4'($urandom);
    endtask

    function automatic logic [3:0] pick_bad();
        logic [3:0] v;
        do v = 4'($urandom); while (v == 4'h5 || v == 4'hD);
        return v;
    endfunction

    // mode 0: valid start nibble; 1: wrong delimiter; 2: drop during preamble.
    task automatic run_frame(input int pre, input int mode, input bit intrude,
                             input bit exp_good, input string req);
        int  done_at = -1;
        int  done_cnt = 0;
        int  mism = 0;
        int  exp_at;
        int  exp_cnt;
        logic g_at = 1'b0, e_at = 1'b0;
        bit  recv = (mode == 0);
        rx_cnt = 0;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_nib = 4'h5;
        end
        if (mode != 2) begin
            @(negedge clk); rx_valid = 1'b1;
            rx_nib = (mode == 1) ? pick_bad() : 4'hD;
            for (int i = 0; i < tx_len; i++) begin
                @(negedge clk); rx_nib = tx_nib[i];
            end
        end
        @(negedge clk); rx_valid = 1'b0; rx_nib = 4'($urandom);
        if (recv && tx_len >= 2)
            chk(data_en && data_nib == tx_nib[tx_len-2], "R5", "second-last nibble at drop",
                {data_en, data_nib}, {1'b1, tx_nib[tx_len-2]});
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (frame_done) begin
                done_cnt++;
                if (done_at < 0) begin done_at = k; g_at = crc_good; e_at = frame_err; end
            end
            if (recv && k == 1 && tx_len >= 1)
                chk(data_en && data_nib == tx_nib[tx_len-1], "R5", "last nibble after drop",
                    {data_en, data_nib}, {1'b1, tx_nib[tx_len-1]});
            if (recv && k == 2)
                chk(!data_en, "R5", "strobe low after drain", data_en, 0);
            if (k >= 6 && done_at > 0)
                chk(crc_good == g_at && frame_err == e_at, "R9", "flags held after done",
                    {crc_good, frame_err}, {g_at, e_at});
            if (intrude) begin
                rx_valid = (k <= 4);
                rx_nib   = 4'hD;
            end
        end
        exp_at = recv ? 4 : 1;
        chk(done_at == exp_at, (mode == 2) ? "R4" : "R9", "done clock", done_at, exp_at);
        chk(done_cnt == 1, "R9", "done width", done_cnt, 1);
        chk(g_at == exp_good && e_at == !exp_good, req, "status flags",
            {g_at, e_at}, {exp_good, !exp_good});
        exp_cnt = recv ? tx_len : 0;
        chk(rx_cnt == exp_cnt, recv ? (intrude ? "R10" : "R2") : "R3", "delivered count",
            rx_cnt, exp_cnt);
        if (recv && rx_cnt == exp_cnt) begin
            for (int i = 0; i < rx_cnt; i++) if (rx_got[i] != tx_nib[i]) mism++;
            chk(mism == 0, "R2", "delivered nibble mismatches", mism, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        int kind, pre;
        s = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!data_en, "R1", "data_en in reset", data_en, 0);
        chk(!frame_done, "R1", "frame_done in reset", frame_done, 0);
        chk(!crc_good, "R1", "crc_good in reset", crc_good, 0);
        chk(!frame_err, "R1", "frame_err in reset", frame_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        build_good(16, 0); run_frame(15, 0, 0, 1, "R6");   // R6 long preamble
        build_good(4, 0);  run_frame(0, 0, 0, 1, "R6");    // R2 zero preamble
        build_good(10, 1); run_frame(7, 0, 0, 0, "R7");    // R7 bit flip
        build_good(0, 0);  run_frame(3, 0, 0, 1, "R8");    // R8 exactly 8 nibbles
        build_raw(7);      run_frame(3, 0, 0, 0, "R8");    // R8 seven nibbles
        build_raw(1);      run_frame(2, 0, 0, 0, "R8");    // R8 one nibble
        build_raw(0);      run_frame(5, 2, 0, 0, "R4");    // R4 drop in preamble
        build_raw(12);     run_frame(6, 1, 0, 0, "R3");    // R3 wrong delimiter
        build_good(6, 0);  run_frame(4, 0, 1, 1, "R10");   // R10 strobe during end

        for (int n = 0; n < 40; n++) begin
            kind = int'($urandom_range(0, 5));
            pre  = int'($urandom_range(1, 20));
            case (kind)
                0: begin build_good(int'($urandom_range(0, 24)), 0); run_frame(pre - 1, 0, 0, 1, "R6"); end
                1: begin build_good(int'($urandom_range(0, 24)), 1); run_frame(pre, 0, 0, 0, "R7"); end
                2: begin build_raw(int'($urandom_range(1, 7))); run_frame(pre, 0, 0, 0, "R8"); end
                3: begin build_raw(0); run_frame(pre, 2, 0, 0, "R4"); end
                4: begin build_raw(int'($urandom_range(0, 20))); run_frame(pre - 1, 1, 0, 0, "R3"); end
                default: begin build_good(int'($urandom_range(1, 12)), 0); run_frame(pre, 0, 1, 1, "R10"); end
            endcase
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule